// File: doc/BRIEF.md
# Adaptive Two-Line Composite Luma/Chroma Separator

This block splits an 8-bit composite NTSC sample stream, taken at four samples per colour-subcarrier period, into an 8-bit luminance stream and an 8-bit chrominance stream. It keeps one video line of past samples. It runs a subcarrier-centred band-pass on both the current line and the stored line. It then picks chroma per sample. Where the two lines agree, it uses a two-line comb. Where they disagree, it uses the band-pass result alone. Between those two cases it blends linearly.

Luminance is the centre composite sample minus the chosen chroma, saturated to 0..255. Chroma is sent out offset by 128. The killer input is latched on each line-start sample. While it is latched high, the block turns separation off: luminance carries the composite sample unchanged and chroma rests at 128.

Every part of the datapath advances only on samples with `in_valid` set. Each output sample describes the input sample taken two valid samples before the one that produced it.

Top module: `ycs_separator`

## Requirements
- R1: While reset is held, and until the first valid sample, `out_valid` is 0, `y_out` is 0 and `c_out` is 128.
- R2: The stored-line sample that is read for a valid input is the sample written at the same line address. The address becomes 0 on a valid sample with `line_start` high. Otherwise it advances by one per valid sample and wraps from LINE_LEN-1 to 0. With the default, a line is 910 samples.
- R3: Let x[n] be the newest valid sample. For each line, band-pass b = floor((2*x[n-2] - x[n] - x[n-4]) / 4), a signed value, and low-pass l = floor((x[n] + 2*x[n-2] + x[n-4]) / 4).
- R4: If |l_cur - l_del| <= TH_LO (default 8), chroma is the comb value floor((b_cur - b_del) / 2).
- R5: If |l_cur - l_del| >= TH_LO + 2^BLEND_SHIFT (default 24), chroma is b_cur.
- R6: Between the two thresholds, chroma = comb + floor((b_cur - comb) * (d - TH_LO) / 2^BLEND_SHIFT), where d = |l_cur - l_del|. The result always lies between comb and b_cur.
- R7: In separation mode, `c_out` = chroma + 128 and `y_out` = x[n-2] - chroma, clamped to 0..255.
- R8: `killer` is sampled only on a valid sample with `line_start` high, and it takes effect from the next valid sample. While the latched value is 1, `y_out` = x[n-2] and `c_out` = 128. Changes to `killer` on other samples have no effect.
- R9: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. In cycles after an idle cycle, `y_out` and `c_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, four times the subcarrier |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a composite sample on `cvbs_in` |
| line_start | input | 1 | Marks the first sample of a line |
| killer | input | 1 | Separation-off request, latched at line start |
| cvbs_in | input | 8 | Composite sample, unsigned |
| out_valid | output | 1 | Marks a new output sample pair |
| y_out | output | 8 | Luminance, unsigned |
| c_out | output | 8 | Chrominance, offset by 128 |

## Verification
The stimulus builds lines whose luma offsets differ by chosen amounts, with a chroma pattern whose sign flips each line. This drives the line-to-line difference below, between and above the two thresholds. A wrong threshold comparison or a wrong blend rounding then shows up as chroma off by a few codes. Saturating values of 0 and 255 expose luma that wraps instead of clamping.

A short line followed by a line start, and a line longer than the delay, check that the address restarts and wraps. A block that ignored either case would comb against the wrong samples. The killer input toggles randomly away from line starts, so a block that sampled it every cycle would drop in and out of bypass within a line.

// File: rtl/ycs_pkg.sv
// Package: shared sample types for the luma/chroma separator.
// Assumes 8-bit unsigned composite samples and 8-bit signed chroma.
package ycs_pkg;
    typedef logic [7:0]        sample_t;
    typedef logic signed [7:0] chroma_t;
    localparam sample_t CHROMA_ZERO = 8'd128;
endpackage

// File: rtl/ycs_line_delay.sv
// Module: one-line sample store.
// Each enabled sample reads the entry at the current line address before the
// same address is written. The address restarts at 0 on a restart sample and
// wraps after LINE_LEN-1. Assumes LINE_LEN >= 2. Contents are not reset.
module ycs_line_delay #(
    parameter int LINE_LEN = 910,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

    logic [W-1:0]  store [LINE_LEN];
    logic [AW-1:0] addr;
    logic [AW-1:0] cur;

    // Address in use for this sample: a restart forces entry 0.
    always_comb cur = restart ? '0 : addr;

    // Read the stored previous-line sample, ahead of this cycle's write.
    always_comb dout = store[cur];

    // Write the incoming sample over the entry just read.
    always_ff @(posedge clk) begin
        if (en) store[cur] <= din;
    end

    // Advance the line address with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                      addr <= '0;
        else if (en) begin
            if (cur == AW'(LINE_LEN - 1)) addr <= '0;
            else                          addr <= cur + AW'(1);
        end
    end

    assert_addr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr < AW'(LINE_LEN));
    assert_restart_to_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> (addr == AW'(1)));
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(addr));
endmodule

// File: rtl/ycs_tap_filter.sv
// Module: five-sample window holding the chroma band-pass and its low-pass complement.
// The window advances on enabled samples. The centre tap is the sample two
// enabled samples back. Outputs are combinational from the window and din.
module ycs_tap_filter
    import ycs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  sample_t din,
    output chroma_t bp,
    output sample_t lp,
    output sample_t center
);
    localparam int DEPTH = 4;

    sample_t              hist [1:DEPTH];
    logic signed [10:0]   bp_acc;
    logic signed [10:0]   bp_sh;
    logic [9:0]           lp_acc;

    // Shift the sample history on each enabled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= DEPTH; i++) hist[i] <= '0;
        end else if (en) begin
            hist[1] <= din;
            for (int i = 2; i <= DEPTH; i++) hist[i] <= hist[i-1];
        end
    end

    // Kernel [-1 0 2 0 -1]/4 with floor, and [1 0 2 0 1]/4 for low-pass.
    always_comb begin
        bp_acc = $signed({2'b00, hist[2], 1'b0}) - $signed({3'b000, din})
               - $signed({3'b000, hist[4]});
        bp_sh  = bp_acc >>> 2;
        bp     = bp_sh[7:0];
        lp_acc = {2'b00, din} + {1'b0, hist[2], 1'b0} + {2'b00, hist[4]};
        lp     = lp_acc[9:2];
        center = hist[2];
    end
endmodule

// File: rtl/ycs_chroma_select.sv
// Module: adaptive choice between comb chroma and band-pass chroma.
// Purely combinational. The line agreement is the absolute low-pass
// difference d. d <= TH_LO picks the comb, d >= TH_LO + 2^BLEND_SHIFT picks
// the band-pass, and the band between is blended linearly with floor.
module ycs_chroma_select
    import ycs_pkg::*;
#(
    parameter int TH_LO       = 8,
    parameter int BLEND_SHIFT = 4
) (
    input  chroma_t bp_cur,
    input  chroma_t bp_del,
    input  sample_t lp_cur,
    input  sample_t lp_del,
    output chroma_t chroma
);
    localparam int TH_HI = TH_LO + (1 << BLEND_SHIFT);
    localparam int PW    = 10 + BLEND_SHIFT;

    logic [8:0]                  ldiff;
    logic [8:0]                  mag;
    logic [8:0]                  off;
    logic signed [8:0]           cdiff;
    logic signed [8:0]           comb_w;
    chroma_t                     comb_c;
    logic signed [8:0]           delta;
    logic signed [BLEND_SHIFT:0] wgt;
    logic signed [PW-1:0]        prod;
    logic signed [PW-1:0]        mix;

    // Agreement metric between the two lines.
    always_comb begin
        ldiff = {1'b0, lp_cur} - {1'b0, lp_del};
        mag   = ldiff[8] ? (~ldiff + 9'd1) : ldiff;
        off   = mag - 9'(TH_LO);
    end

    // Comb chroma: half the line-to-line band-pass difference, floored.
    always_comb begin
        cdiff  = $signed({bp_cur[7], bp_cur}) - $signed({bp_del[7], bp_del});
        comb_w = cdiff >>> 1;
        comb_c = comb_w[7:0];
    end

    // Linear blend from comb toward band-pass in the transition band.
    always_comb begin
        delta = $signed({bp_cur[7], bp_cur}) - $signed({comb_c[7], comb_c});
        wgt   = $signed({1'b0, off[BLEND_SHIFT-1:0]});
        prod  = PW'(delta) * PW'(wgt);
        mix   = PW'(comb_c) + (prod >>> BLEND_SHIFT);
    end

    // Final selection by region.
    always_comb begin
        if (mag <= 9'(TH_LO))      chroma = comb_c;
        else if (mag >= 9'(TH_HI)) chroma = bp_cur;
        else                       chroma = mix[7:0];
    end

    // The selected chroma never leaves the span between comb and band-pass.
    always_comb begin
        assert_blend_bounded_R6: assert ((chroma >= comb_c && chroma <= bp_cur) ||
                                         (chroma <= comb_c && chroma >= bp_cur));
    end
endmodule

// File: rtl/ycs_separator.sv
// Module: top of the adaptive two-line luma/chroma separator.
// All state advances on in_valid. The outputs are registered, one cycle after
// the sample that produced them, and describe the input two valid samples
// earlier. killer is latched on line-start samples only.
module ycs_separator
    import ycs_pkg::*;
#(
    parameter int LINE_LEN    = 910,
    parameter int TH_LO       = 8,
    parameter int BLEND_SHIFT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       line_start,
    input  logic       killer,
    input  logic [7:0] cvbs_in,
    output logic       out_valid,
    output logic [7:0] y_out,
    output logic [7:0] c_out
);
    sample_t           del_sample;
    chroma_t           bp_cur, bp_del, chroma;
    sample_t           lp_cur, lp_del, ctr_cur, ctr_del;
    logic              kill_q;
    logic signed [9:0] y_wide;
    sample_t           y_sat;

    ycs_line_delay #(.LINE_LEN(LINE_LEN), .W(8)) u_delay (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .restart(line_start),
        .din(cvbs_in), .dout(del_sample)
    );

    ycs_tap_filter u_cur_filt (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(cvbs_in),
        .bp(bp_cur), .lp(lp_cur), .center(ctr_cur)
    );

    ycs_tap_filter u_del_filt (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(del_sample),
        .bp(bp_del), .lp(lp_del), .center(ctr_del)
    );

    ycs_chroma_select #(.TH_LO(TH_LO), .BLEND_SHIFT(BLEND_SHIFT)) u_sel (
        .bp_cur(bp_cur), .bp_del(bp_del), .lp_cur(lp_cur), .lp_del(lp_del),
        .chroma(chroma)
    );

    // Luma is centre minus chroma, clamped to the unsigned 8-bit range.
    always_comb begin
        y_wide = $signed({2'b00, ctr_cur}) - $signed({{2{chroma[7]}}, chroma});
        if (y_wide < 0)                y_sat = 8'd0;
        else if (y_wide > 10'sd255)    y_sat = 8'd255;
        else                           y_sat = y_wide[7:0];
    end

    // Latch the killer request on line-start samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                       kill_q <= 1'b0;
        else if (in_valid && line_start)  kill_q <= killer;
    end

    // Register the output pair and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_out     <= '0;
            c_out     <= CHROMA_ZERO;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (kill_q) begin
                    y_out <= ctr_cur;
                    c_out <= CHROMA_ZERO;
                end else begin
                    y_out <= y_sat;
                    c_out <= {~chroma[7], chroma[6:0]};
                end
            end
        end
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(y_out) && $stable(c_out)));
    assert_kill_chroma_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kill_q) |=> (c_out == CHROMA_ZERO));
    assert_kill_latch_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && line_start) |=> $stable(kill_q));
endmodule

// File: tb/tb_ycs_separator.sv
module tb_ycs_separator;
    localparam int LL    = 910;
    localparam int TH_LO = 8;
    localparam int BS    = 4;
    localparam int TH_HI = TH_LO + (1 << BS);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       line_start = 1'b0;
    logic       killer = 1'b0;
    logic [7:0] cvbs_in = 8'd0;
    logic       out_valid;
    logic [7:0] y_out, c_out;

    always #10 clk = ~clk;

    ycs_separator #(.LINE_LEN(LL), .TH_LO(TH_LO), .BLEND_SHIFT(BS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_start(line_start),
        .killer(killer), .cvbs_in(cvbs_in), .out_valid(out_valid),
        .y_out(y_out), .c_out(c_out)
    );

    int checks = 0, errors = 0;
    int hit4 = 0, hit5 = 0, hit6 = 0, hit8 = 0, hitsat = 0;
    int mem_m [LL];
    int addr_m = 0, nwr = 0, parity = 0;
    int xh [5];
    int dh [5];
    bit kill_m = 1'b0;
    bit pend_v = 1'b0, pend_chk = 1'b0;
    int pend_y = 0, pend_c = 128;
    string pend_tag = "";
    int last_y = 0, last_c = 128;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fdiv(int n, int d);
        if (n >= 0) return n / d;
        return -((-n + d - 1) / d);
    endfunction

    // Compare the outputs produced at the last edge against the pending expectation.
    task automatic observe();
        chk("R9 out_valid", int'(out_valid), int'(pend_v));
        if (pend_v && pend_chk) begin
            chk({pend_tag, " c_out"}, int'(c_out), pend_c);
            chk({pend_tag, " R7 y_out"}, int'(y_out), pend_y);
        end else if (!pend_v) begin
            chk("R9 y hold", int'(y_out), last_y);
            chk("R9 c hold", int'(c_out), last_c);
        end
        last_y = y_out;
        last_c = c_out;
    endtask

    // Reference model for one valid sample (R2, R3, R4, R5, R6, R7, R8).
    task automatic model(bit ls, bit k, int s);
        int cur, rd, bc, bd, lc, ld, cc, d, sel, yv;
        cur = ls ? 0 : addr_m;
        rd  = mem_m[cur];
        bc  = fdiv(2 * xh[2] - s - xh[4], 4);
        lc  = (s + 2 * xh[2] + xh[4]) / 4;
        bd  = fdiv(2 * dh[2] - rd - dh[4], 4);
        ld  = (rd + 2 * dh[2] + dh[4]) / 4;
        cc  = fdiv(bc - bd, 2);
        d   = (lc > ld) ? lc - ld : ld - lc;
        pend_chk = (nwr >= LL + 8);
        if (d <= TH_LO) begin
            sel = cc; pend_tag = "R4 comb";
            if (pend_chk && !kill_m) hit4++;
        end else if (d >= TH_HI) begin
            sel = bc; pend_tag = "R5 bandpass";
            if (pend_chk && !kill_m) hit5++;
        end else begin
            sel = cc + fdiv((bc - cc) * (d - TH_LO), 1 << BS); pend_tag = "R6 blend";
            if (pend_chk && !kill_m) hit6++;
        end
        if (kill_m) begin
            pend_y = xh[2]; pend_c = 128; pend_tag = "R8 killer";
            if (pend_chk) hit8++;
        end else begin
            yv = xh[2] - sel;
            if (yv < 0 || yv > 255) begin
                if (pend_chk) hitsat++;
                pend_tag = {pend_tag, " R7 sat"};
            end
            pend_y = (yv < 0) ? 0 : (yv > 255) ? 255 : yv;
            pend_c = sel + 128;
        end
        mem_m[cur] = s;
        addr_m = (cur == LL - 1) ? 0 : cur + 1;
        for (int i = 4; i >= 2; i--) begin
            xh[i] = xh[i-1];
            dh[i] = dh[i-1];
        end
        xh[1] = s;
        dh[1] = rd;
        if (ls) kill_m = k;
        nwr++;
    endtask

    task automatic step(bit v, bit ls, bit k, int s);
        @(negedge clk);
        observe();
        in_valid = v; line_start = ls; killer = k; cvbs_in = s[7:0];
        pend_v = v; pend_chk = 1'b0;
        if (v) model(ls, k, s);
    endtask

    // One line: kind 0 random, 1 structured with alternating chroma, 2 extremes.
    task automatic send_line(int kind, int len, bit ls_first, bit kval, int offs);
        int sgn;
        sgn = parity ? -1 : 1;
        for (int i = 0; i < len; i++) begin
            int v, pat;
            pat = (i % 4 == 1) ? 30 * sgn : (i % 4 == 3) ? -30 * sgn : 0;
            case (kind)
                0:       v = int'($urandom % 256);
                1:       v = 90 + ((i / 64) % 3) * 25 + offs + pat;
                default: v = ($urandom % 2) ? 255 : 0;
            endcase
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            if ($urandom % 6 == 0) step(1'b0, 1'b0, 1'($urandom % 2), int'($urandom % 256));
            if (ls_first && i == 0) step(1'b1, 1'b1, kval, v);
            else                    step(1'b1, 1'b0, 1'($urandom % 2), v);
        end
        parity ^= 1;
    endtask

    function automatic int pick_off();
        case ($urandom % 6)
            0: return 0;
            1: return 4;
            2: return 12;
            3: return 16;
            4: return 20;
            default: return 40;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h1c5e_0a11));
        for (int i = 0; i < 5; i++) begin
            xh[i] = 0; dh[i] = 0;
        end
        for (int i = 0; i < LL; i++) mem_m[i] = 0;
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 y_out", int'(y_out), 0);
        chk("R1 c_out", int'(c_out), 128);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle out_valid", int'(out_valid), 0);
        chk("R1 idle c_out", int'(c_out), 128);
        // Priming line, then structured lines covering all regions (R4, R5, R6).
        send_line(1, LL, 1'b1, 1'b0, 0);
        for (int n = 0; n < 5; n++) send_line(1, LL, 1'b1, 1'b0, pick_off());
        send_line(0, LL, 1'b1, 1'b0, 0);
        send_line(2, LL, 1'b1, 1'b0, 0);
        // R8: killer latched at line start, random elsewhere.
        send_line(1, LL, 1'b1, 1'b1, 0);
        send_line(1, LL, 1'b1, 1'b1, 12);
        send_line(1, LL, 1'b1, 1'b0, 12);
        // R2: short line, then restart; then a line longer than the store.
        send_line(1, 300, 1'b1, 1'b0, 4);
        send_line(1, LL, 1'b1, 1'b0, 4);
        send_line(1, LL + 40, 1'b1, 1'b0, 16);
        send_line(1, LL, 1'b1, 1'b0, 16);
        step(1'b0, 1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 1'b0, 0);
        chk("R4 comb region reached", int'(hit4 > 0), 1);
        chk("R5 bandpass region reached", int'(hit5 > 0), 1);
        chk("R6 blend region reached", int'(hit6 > 0), 1);
        chk("R8 killer samples reached", int'(hit8 > 0), 1);
        chk("R7 saturation reached", int'(hitsat > 0), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule